// File: doc/BRIEF.md
# Narrow-to-Wide Register Access Bridge

This block lets a host that only issues 32-bit register accesses reach a space of 64-bit registers on a downstream register bus. The host stages a 64-bit value as two 32-bit halves in a small local register file, upper half first, and then starts one downstream access by writing a command word. Bit 31 of that word picks the direction. The remaining 31 bits are a register offset, which is added to a fixed block base address. The result drives the downstream address.

A downstream read returns its 64-bit result into the two data registers. The host then fetches the result as two 32-bit reads. A status word carries a busy bit while an access is in flight and a sticky error bit. The host polls the error bit after every command. The error bit is set by a downstream error response or by a command issued while busy. Only a write to the reset word clears it, and that write also empties the data registers.

Top module: `wide_reg_bridge`

## Requirements
- R1: After rst_n is sampled low, every host register reads zero and dn_req is low, including when reset arrives in the middle of an access.
- R2: Host byte addresses are 0x00 for the upper data word (value bits 63:32) and 0x04 for the lower data word (bits 31:0). Both read back what the host last wrote. Address 0x20 and unmapped addresses read zero, and writes to them have no effect.
- R3: A host write to 0x08 with bit 31 set starts a downstream write. From the next cycle dn_req=1, dn_we=1, dn_wdata={upper word, lower word} and dn_addr=BASE_ADDR plus bits 30:0 of the command.
- R4: A host write to 0x08 with bit 31 clear starts a downstream read with dn_we=0 and the same address rule. At the edge where dn_ack is sampled high without dn_err, dn_rdata[63:32] goes to the upper word and dn_rdata[31:0] to the lower word, readable in the next cycle.
- R5: dn_req, dn_we, dn_addr and dn_wdata hold steady until dn_ack is sampled high. dn_req falls in the following cycle.
- R6: STATUS (0x1C) bit 0 is the busy bit. It is 1 from the cycle after a command is accepted until the cycle after dn_ack.
- R7: A command written while busy is dropped, so the access in flight keeps its address and direction, and it sets STATUS bit 31.
- R8: dn_ack together with dn_err sets STATUS bit 31. A read that ends this way leaves both data words unchanged.
- R9: STATUS bit 31 stays set through later successful accesses until any host write to 0x18. That write clears the bit and zeroes both data words.
- R10: Host writes to the data words while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr, combinational |
| dn_req | output | 1 | Downstream access request, held until acknowledged |
| dn_we | output | 1 | Downstream direction, 1 for write |
| dn_addr | output | DA_W | Downstream register address |
| dn_wdata | output | 64 | Downstream write data |
| dn_rdata | input | 64 | Downstream read data, valid with dn_ack |
| dn_ack | input | 1 | Downstream completion |
| dn_err | input | 1 | Downstream error response, valid with dn_ack |

## Verification
A command written on one edge shows on the downstream outputs and in the busy bit one cycle later. A completion sampled on one edge has cleared dn_req and busy, updated the error bit and latched read data by the next cycle. The host read port is combinational, so a status or data read reflects the registers the moment host_addr settles. The bench drives every stimulus on a falling edge. It then reads results on the next falling edge, one register stage later, and holds the acknowledge back for a per-vector number of cycles so the hold rule is checked across several idle cycles.

// File: rtl/wrb_pkg.sv
// Shared constants for the narrow-to-wide register bridge.
// Assumes a 32-bit host word and a 64-bit downstream word.
package wrb_pkg;
    localparam int HW      = 32;
    localparam int WW      = 2 * HW;
    localparam int HA_W    = 8;
    localparam int DIR_BIT = HW - 1;   // command bit selecting write
    localparam int ERR_BIT = HW - 1;   // sticky error flag in status
    localparam int BSY_BIT = 0;        // busy flag in status

    localparam logic [HA_W-1:0] A_HI   = 8'h00;
    localparam logic [HA_W-1:0] A_LO   = 8'h04;
    localparam logic [HA_W-1:0] A_CMD  = 8'h08;
    localparam logic [HA_W-1:0] A_CLR  = 8'h18;
    localparam logic [HA_W-1:0] A_STAT = 8'h1C;
    localparam logic [HA_W-1:0] A_IRQ  = 8'h20;
endpackage

// File: rtl/wrb_wide_port.sv
// Downstream access engine: latches an accepted command, raises the
// request and holds address, direction and data until acknowledged.
// Assumes start is only raised while no access is in flight.
module wrb_wide_port
    import wrb_pkg::*;
#(
    parameter int unsigned     DA_W      = 32,
    parameter logic [DA_W-1:0] BASE_ADDR = 'h70000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [HW-1:0]   start_word,
    input  logic [WW-1:0]   stage_data,
    input  logic            dn_ack,
    output logic            busy,
    output logic            done,
    output logic            is_read,
    output logic            dn_req,
    output logic            dn_we,
    output logic [DA_W-1:0] dn_addr,
    output logic [WW-1:0]   dn_wdata
);
    localparam int OFF_W = HW - 1;

    logic            req_q;
    logic            we_q;
    logic [DA_W-1:0] addr_q;
    logic [WW-1:0]   wdata_q;
    logic [DA_W-1:0] offset;

    assign offset = DA_W'(start_word[OFF_W-1:0]);

    // Launch an access on start, retire it on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start && !req_q) begin
            req_q   <= 1'b1;
            we_q    <= start_word[DIR_BIT];
            addr_q  <= BASE_ADDR + offset;
            wdata_q <= start_word[DIR_BIT] ? stage_data : '0;
        end else if (req_q && dn_ack) begin
            req_q   <= 1'b0;
        end
    end

    assign busy     = req_q;
    assign done     = req_q && dn_ack;
    assign is_read  = !we_q;
    assign dn_req   = req_q;
    assign dn_we    = we_q;
    assign dn_addr  = addr_q;
    assign dn_wdata = wdata_q;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_ack |=> dn_req); // R5
    AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && !dn_ack |=> $stable(dn_addr) && $stable(dn_we) && $stable(dn_wdata)); // R5
    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req && dn_ack |=> !dn_req); // R5
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !req_q); // R7
endmodule

// File: rtl/wrb_host_regs.sv
// Host-side register file: two staging words, command and reset decode,
// status with sticky error, combinational read mux.
// Assumes one host write strobe per cycle and byte addressing.
module wrb_host_regs
    import wrb_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr_en,
    input  logic [HA_W-1:0] host_addr,
    input  logic [HW-1:0]   host_wdata,
    output logic [HW-1:0]   host_rdata,
    input  logic            busy,
    input  logic            done,
    input  logic            is_read,
    input  logic            dn_err,
    input  logic [WW-1:0]   dn_rdata,
    output logic            start,
    output logic [HW-1:0]   start_word,
    output logic [WW-1:0]   stage_data
);
    logic                cmd_wr;
    logic                clr_wr;
    logic                err_q;
    logic                rd_ok;
    logic [1:0][HW-1:0]  half_w;

    assign cmd_wr     = host_wr_en && (host_addr == A_CMD);
    assign clr_wr     = host_wr_en && (host_addr == A_CLR);
    assign start      = cmd_wr && !busy;
    assign start_word = host_wdata;
    assign rd_ok      = done && is_read && !dn_err;

    // Sticky error: set by rejected command or error response, cleared by reset word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (clr_wr)
            err_q <= 1'b0;
        else if ((cmd_wr && busy) || (done && dn_err))
            err_q <= 1'b1;
    end

    // One staging word per half; index 1 is the upper half.
    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam logic [HA_W-1:0] MY_ADDR = (h == 1) ? A_HI : A_LO;
        logic [HW-1:0] half_q;

        // Staging word: reset word clears, read result loads, host write loads when idle.
        always_ff @(posedge clk) begin
            if (!rst_n)
                half_q <= '0;
            else if (clr_wr)
                half_q <= '0;
            else if (rd_ok)
                half_q <= dn_rdata[h*HW +: HW];
            else if (host_wr_en && (host_addr == MY_ADDR) && !busy)
                half_q <= host_wdata;
        end

        assign half_w[h] = half_q;
    end

    assign stage_data = half_w;

    // Host read mux; unmapped and interrupt addresses read zero.
    always_comb begin
        host_rdata = '0;
        case (host_addr)
            A_HI:    host_rdata = half_w[1];
            A_LO:    host_rdata = half_w[0];
            A_STAT: begin
                host_rdata[ERR_BIT] = err_q;
                host_rdata[BSY_BIT] = busy;
            end
            A_IRQ:   host_rdata = '0;
            default: host_rdata = '0;
        endcase
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !clr_wr |=> err_q); // R9
    AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && busy |=> err_q); // R7
    AST_DERR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        done && dn_err && !clr_wr |=> err_q); // R8
    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done && !clr_wr |=> $stable(stage_data)); // R10
    AST_CLEAR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> !err_q && (stage_data == '0)); // R9
endmodule

// File: rtl/wide_reg_bridge.sv
// Top of the narrow-to-wide bridge: host register file plus downstream
// access engine. Assumes the downstream side answers every request with
// one dn_ack pulse, with dn_err and dn_rdata valid alongside it.
module wide_reg_bridge
    import wrb_pkg::*;
#(
    parameter int unsigned     DA_W      = 32,
    parameter logic [DA_W-1:0] BASE_ADDR = 'h70000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr_en,
    input  logic [7:0]      host_addr,
    input  logic [31:0]     host_wdata,
    output logic [31:0]     host_rdata,
    output logic            dn_req,
    output logic            dn_we,
    output logic [DA_W-1:0] dn_addr,
    output logic [63:0]     dn_wdata,
    input  logic [63:0]     dn_rdata,
    input  logic            dn_ack,
    input  logic            dn_err
);
    logic          busy;
    logic          done;
    logic          is_read;
    logic          start;
    logic [HW-1:0] start_word;
    logic [WW-1:0] stage_data;

    wrb_host_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr_en (host_wr_en),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .done       (done),
        .is_read    (is_read),
        .dn_err     (dn_err),
        .dn_rdata   (dn_rdata),
        .start      (start),
        .start_word (start_word),
        .stage_data (stage_data)
    );

    wrb_wide_port #(
        .DA_W      (DA_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_word (start_word),
        .stage_data (stage_data),
        .dn_ack     (dn_ack),
        .busy       (busy),
        .done       (done),
        .is_read    (is_read),
        .dn_req     (dn_req),
        .dn_we      (dn_we),
        .dn_addr    (dn_addr),
        .dn_wdata   (dn_wdata)
    );
endmodule

// File: tb/wide_reg_bridge_tb_top.sv
`timescale 1ns/1ps
module wide_reg_bridge_tb_top;
    localparam logic [31:0] BASE = 32'h0007_0000;
    localparam logic [7:0] A_HI = 8'h00, A_LO = 8'h04, A_CMD = 8'h08,
                           A_CLR = 8'h18, A_STAT = 8'h1C, A_IRQ = 8'h20;

    typedef struct packed {
        logic        wr;
        logic [30:0] off;
        logic [63:0] wd;
        logic [63:0] rd;
        logic        err;
        logic [3:0]  hold;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b1, 31'h0000_0005, 64'h0123_4567_89AB_CDEF, 64'h0, 1'b0, 4'd1},
        '{1'b0, 31'h0000_0006, 64'h1111_2222_3333_4444, 64'hCAFE_F00D_DEAD_BEEF, 1'b0, 4'd3},
        '{1'b1, 31'h0000_0003, 64'hFFFF_FFFF_0000_0001, 64'h0, 1'b1, 4'd0},
        '{1'b0, 31'h0000_0008, 64'h5555_6666_7777_8888, 64'hAAAA_BBBB_CCCC_DDDD, 1'b1, 4'd2},
        '{1'b1, 31'h7FFF_FFFF, 64'h8000_0000_0000_0000, 64'h0, 1'b0, 4'd5},
        '{1'b0, 31'h0000_0000, 64'h0, 64'h0F0F_0F0F_F0F0_F0F0, 1'b0, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        dn_req, dn_we;
    logic [31:0] dn_addr;
    logic [63:0] dn_wdata;
    logic [63:0] dn_rdata = '0;
    logic        dn_ack = 1'b0;
    logic        dn_err = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    wide_reg_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .dn_req(dn_req),
        .dn_we(dn_we), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
        .dn_ack(dn_ack), .dn_err(dn_err)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 1'b0; host_wdata = '0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic give_ack(input logic [63:0] rd, input logic e);
        @(negedge clk);
        dn_ack = 1'b1; dn_rdata = rd; dn_err = e;
        @(negedge clk);
        dn_ack = 1'b0; dn_rdata = '0; dn_err = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [31:0] exp_hi, exp_lo;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 dn_req after reset", dn_req, 0);
        host_read(A_HI, r);   check("R1 upper word", r, 0);
        host_read(A_LO, r);   check("R1 lower word", r, 0);
        host_read(A_STAT, r); check("R1 status", r, 0);

        // R2: readback and zero-reading addresses
        host_write(A_HI, 32'hA5A5_0001);
        host_write(A_LO, 32'h5A5A_0002);
        host_write(A_IRQ, 32'hFFFF_FFFF);
        host_write(8'h0C, 32'hFFFF_FFFF);
        host_read(A_HI, r);  check("R2 upper readback", r, 32'hA5A5_0001);
        host_read(A_LO, r);  check("R2 lower readback", r, 32'h5A5A_0002);
        host_read(A_IRQ, r); check("R2 irq word reads zero", r, 0);
        host_read(8'h0C, r); check("R2 unmapped reads zero", r, 0);
        check("R2 no access from stray writes", dn_req, 0);

        // Vector table: R3 R4 R5 R6 R8
        for (int i = 0; i < 6; i++) begin
            host_write(A_CLR, 32'h0);
            host_write(A_HI, VECS[i].wd[63:32]);
            host_write(A_LO, VECS[i].wd[31:0]);
            host_write(A_CMD, {VECS[i].wr, VECS[i].off});
            check("R3 request raised", dn_req, 1);
            check("R3 R4 direction", dn_we, VECS[i].wr);
            check("R3 address", dn_addr, BASE + {1'b0, VECS[i].off});
            if (VECS[i].wr) check("R3 write data", dn_wdata, VECS[i].wd);
            host_read(A_STAT, r); check("R6 busy set", r, 32'h1);
            repeat (VECS[i].hold) @(negedge clk);
            check("R5 request held", dn_req, 1);
            check("R5 address held", dn_addr, BASE + {1'b0, VECS[i].off});
            give_ack(VECS[i].rd, VECS[i].err);
            check("R5 request dropped", dn_req, 0);
            host_read(A_STAT, r);
            check("R6 R8 status after ack", r, VECS[i].err ? 32'h8000_0000 : 32'h0);
            if (!VECS[i].wr && !VECS[i].err) begin
                exp_hi = VECS[i].rd[63:32]; exp_lo = VECS[i].rd[31:0];
            end else begin
                exp_hi = VECS[i].wd[63:32]; exp_lo = VECS[i].wd[31:0];
            end
            host_read(A_HI, r); check("R4 R8 upper word", r, exp_hi);
            host_read(A_LO, r); check("R4 R8 lower word", r, exp_lo);
        end

        // R7 R10 R9: command and data writes while busy, stickiness, clear
        host_write(A_CLR, 32'h0);
        host_write(A_HI, 32'h1234_5678);
        host_write(A_CMD, 32'h0000_0003);
        host_write(A_CMD, 32'h8000_0009);
        check("R7 direction kept", dn_we, 0);
        check("R7 address kept", dn_addr, BASE + 32'h3);
        host_read(A_STAT, r); check("R7 error and busy", r, 32'h8000_0001);
        host_write(A_HI, 32'hDEAD_0000);
        host_read(A_HI, r); check("R10 data write ignored while busy", r, 32'h1234_5678);
        give_ack(64'h0BAD_CAFE_0000_0001, 1'b0);
        host_read(A_HI, r); check("R4 clean read after reject", r, 32'h0BAD_CAFE);
        host_read(A_STAT, r); check("R9 error stays set", r, 32'h8000_0000);
        host_write(A_CLR, 32'h0000_1234);
        host_read(A_STAT, r); check("R9 error cleared", r, 0);
        host_read(A_HI, r); check("R9 upper zeroed", r, 0);
        host_read(A_LO, r); check("R9 lower zeroed", r, 0);

        // R1: reset during an access
        host_write(A_CMD, 32'h8000_0004);
        check("R1 request before reset", dn_req, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 request cleared by reset", dn_req, 0);
        host_read(A_STAT, r); check("R1 status cleared by reset", r, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule